// File: doc/BRIEF.md
# Logical Immediate Bitmask Decoder

This block turns the compact immediate fields of a logical or bitfield instruction into the two masks an execution unit needs. The fields are a one-bit width selector (`wide_n`), a 6-bit size/length field (`imm_s`) and a 6-bit rotate field (`imm_r`). From them the block produces a rotated mask (`wmask`) and a plain low-ones mask (`tmask`). It also reports the element size and flags encodings that have no meaning.

The element size is found from the highest set bit of the seven-bit value formed by `wide_n` above the inverted `imm_s`. Inside one element a run of ones is built and rotated, and the element is then repeated across the datapath. The datapath width is a parameter, 32 or 64. The decode is registered. A request presented with `in_valid` appears on the outputs on the next clock edge, marked by `out_valid`. The outputs hold their last values until the next request.

Top module: `bitmask_decode`

## Requirements
- R1: While reset is active and after its release with no request, `out_valid`, `reserved`, `elem_size`, `wmask` and `tmask` are all zero.
- R2: A request sampled with `in_valid` high at a rising edge drives `out_valid` high after that edge. In every other cycle `out_valid` is low and the other outputs keep their values.
- R3: Let len be the index of the highest set bit of {`wide_n`, ~`imm_s`}. Then `elem_size` equals 2^len. If no bit is set, or len is 0, `reserved` is 1.
- R4: When `logical_mode` is 1 and the low len bits of `imm_s` are all ones, `reserved` is 1. With `logical_mode` 0 the same fields decode normally.
- R5: Let S be the low len bits of `imm_s` and R the low len bits of `imm_r`. Within each element, `wmask` holds S+1 low ones rotated right by R. This pattern is repeated every `elem_size` bits across the datapath.
- R6: Let d be the low len bits of (S − R) taken modulo 64. Within each element, `tmask` holds d+1 low ones, repeated every `elem_size` bits.
- R7: With `XLEN` = 32, a request with `wide_n` = 1 is reserved, because a 64-bit element does not fit. Both masks are then 32 bits wide.
- R8: Whenever `reserved` is 1, `wmask`, `tmask` and `elem_size` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| logical_mode | input | 1 | 1 adds the all-ones reserved check |
| wide_n | input | 1 | Width selector bit of the encoding |
| imm_s | input | 6 | Run-length field |
| imm_r | input | 6 | Rotate field |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| wmask | output | XLEN | Rotated, replicated mask |
| tmask | output | XLEN | Unrotated, replicated low-ones mask |
| elem_size | output | 7 | Element size in bits, 0 when reserved |
| reserved | output | 1 | Encoding is reserved |

## Verification
The assertions assume that reset is asserted before the first request. They also assume that the inputs are stable around each rising edge. The bench meets both: it holds reset over the first cycles and drives every input on the falling edge.

The checker also assumes that a non-reserved result always has a power-of-two element size and a mask with bit 0 of `tmask` set. Every legal combination of the fields satisfies this, so the bench sweeps all 16384 field combinations, back to back, against both a 64-bit and a 32-bit instance.

// File: rtl/bitmask_decode.sv
module bitmask_decode #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            logical_mode,
  input  logic            wide_n,
  input  logic [5:0]      imm_s,
  input  logic [5:0]      imm_r,
  output logic            out_valid,
  output logic [XLEN-1:0] wmask,
  output logic [XLEN-1:0] tmask,
  output logic [6:0]      elem_size,
  output logic            reserved
);
  localparam int LW = $clog2(XLEN);

  logic [6:0] probe;
  logic [2:0] len;
  logic       found;
  logic [5:0] levels, s_eff, r_eff, diff, d_eff;
  logic       bad;
  logic [XLEN-1:0] w_c, t_c;

  assign probe = {wide_n, ~imm_s};

  always_comb begin
    len   = 3'd0;
    found = 1'b0;
    for (int k = 0; k < 7; k++)
      if (probe[k]) begin
        len   = 3'(k);
        found = 1'b1;
      end
  end

  assign levels = 6'((7'd1 << len) - 7'd1);
  assign s_eff  = imm_s & levels;
  assign r_eff  = imm_r & levels;
  assign diff   = s_eff - r_eff;
  assign d_eff  = diff & levels;
  assign bad    = !found || (len == 3'd0) || (int'(len) > LW) ||
                  (logical_mode && (s_eff == levels));

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign w_c[i] = ((6'(i) + r_eff) & levels) <= s_eff;
    assign t_c[i] = (6'(i) & levels) <= d_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wmask     <= '0;
      tmask     <= '0;
      elem_size <= '0;
      reserved  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        reserved  <= bad;
        wmask     <= bad ? '0 : w_c;
        tmask     <= bad ? '0 : t_c;
        elem_size <= bad ? 7'd0 : 7'(7'd1 << len);
      end
    end
  end
endmodule

// File: rtl/bitmask_decode_chk.sv
module bitmask_decode_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            wide_n,
  input logic            out_valid,
  input logic [XLEN-1:0] wmask,
  input logic [XLEN-1:0] tmask,
  input logic [6:0]      elem_size,
  input logic            reserved
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(wmask) && $stable(tmask) && $stable(reserved));
  a_r8_zero_on_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && reserved |-> wmask == '0 && tmask == '0 && elem_size == 7'd0);
  a_r3_size_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !reserved |-> $countones(elem_size) == 1 && elem_size >= 7'd2);
  a_r6_tmask_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !reserved |-> tmask[0] && wmask != '0);
  if (XLEN < 64) begin : g_narrow
    a_r7_narrow_wide_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && wide_n |=> reserved);
  end
endmodule

bind bitmask_decode bitmask_decode_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_n(wide_n),
  .out_valid(out_valid), .wmask(wmask), .tmask(tmask),
  .elem_size(elem_size), .reserved(reserved));

// File: tb/bitmask_decode_test.sv
module bitmask_decode_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, logical_mode = 1'b0, wide_n = 1'b0;
  logic [5:0] imm_s = '0, imm_r = '0;
  logic out_valid, reserved, out_valid32, reserved32;
  logic [63:0] wmask, tmask;
  logic [31:0] wmask32, tmask32;
  logic [6:0] elem_size, elem_size32;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bitmask_decode #(.XLEN(64)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .logical_mode(logical_mode),
    .wide_n(wide_n), .imm_s(imm_s), .imm_r(imm_r), .out_valid(out_valid),
    .wmask(wmask), .tmask(tmask), .elem_size(elem_size), .reserved(reserved));

  bitmask_decode #(.XLEN(32)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .logical_mode(logical_mode),
    .wide_n(wide_n), .imm_s(imm_s), .imm_r(imm_r), .out_valid(out_valid32),
    .wmask(wmask32), .tmask(tmask32), .elem_size(elem_size32), .reserved(reserved32));

  typedef struct {
    logic [63:0] w, t;
    logic [6:0]  es;
    logic        rs;
    logic [31:0] w32, t32;
    logic [6:0]  es32;
    logic        rs32;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t last;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input int xlen, input bit n, input bit [5:0] s, input bit [5:0] r,
                       input bit lg, output logic [63:0] w, output logic [63:0] t,
                       output logic [6:0] es, output logic rs);
    bit [6:0] v;
    int len, esz, sv, rv, dv;
    logic [127:0] el, tel;
    v = {n, ~s};
    len = -1;
    for (int k = 6; k >= 0; k--) if (len < 0 && v[k]) len = k;
    rs = (len < 1);
    esz = (len < 1) ? 0 : (1 << len);
    if (esz > xlen) rs = 1'b1;
    w = '0; t = '0; es = '0;
    if (!rs) begin
      sv = s % esz;
      rv = r % esz;
      if (lg && sv == esz - 1) rs = 1'b1;
      else begin
        dv = ((sv - rv) % esz + esz) % esz;
        el = (128'd1 << (sv + 1)) - 128'd1;
        for (int k = 0; k < rv; k++)
          el = (el >> 1) | (128'(el[0]) << (esz - 1));
        tel = (128'd1 << (dv + 1)) - 128'd1;
        for (int p = 0; p < xlen; p += esz) begin
          w = w | 64'(el << p);
          t = t | 64'(tel << p);
        end
        es = 7'(esz);
      end
    end
  endtask

  task automatic send(input bit n, input bit [5:0] s, input bit [5:0] r,
                      input bit lg, input string tag, input bit idle);
    exp_t e;
    logic [63:0] w, t;
    model(64, n, s, r, lg, e.w, e.t, e.es, e.rs);
    model(32, n, s, r, lg, w, t, e.es32, e.rs32);
    e.w32 = w[31:0];
    e.t32 = t[31:0];
    e.tag = tag;
    in_valid = 1'b1; wide_n = n; imm_s = s; imm_r = r; logical_mode = lg;
    sb.push_back(e);
    @(negedge clk);
    if (idle) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  // Monitor: compares each result with the oldest expected item.
  always @(negedge clk) begin
    if (rst_n && (out_valid || out_valid32)) begin
      if (sb.size() == 0) check(1'b0, "R2", "unexpected out_valid", 64'(out_valid), 64'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        last = e;
        check(out_valid32 == out_valid, "R2", "strobe pair", 64'(out_valid32), 64'(out_valid));
        check(reserved == e.rs, e.tag, "reserved64", 64'(reserved), 64'(e.rs));
        check(elem_size == e.es, "R3", "esize64", 64'(elem_size), 64'(e.es));
        check(wmask == e.w, "R5", "wmask64", wmask, e.w);
        check(tmask == e.t, "R6", "tmask64", tmask, e.t);
        check(reserved32 == e.rs32, "R7", "reserved32", 64'(reserved32), 64'(e.rs32));
        check(elem_size32 == e.es32, "R7", "esize32", 64'(elem_size32), 64'(e.es32));
        check(wmask32 == e.w32, "R7", "wmask32", 64'(wmask32), 64'(e.w32));
        check(tmask32 == e.t32, "R7", "tmask32", 64'(tmask32), 64'(e.t32));
        if (e.rs) check(wmask == 0 && tmask == 0, "R8", "masks zero", wmask | tmask, 64'd0);
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 0 && reserved == 0 && elem_size == 0 && wmask == 0 && tmask == 0,
          "R1", "reset state", wmask | tmask | 64'(elem_size), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && wmask == 0, "R1", "idle after reset", wmask, 64'd0);

    send(1'b1, 6'b000000, 6'd0,  1'b1, "R3", 1'b1);
    send(1'b0, 6'b111100, 6'd1,  1'b1, "R5", 1'b1);
    send(1'b0, 6'b111111, 6'd0,  1'b0, "R3", 1'b1);
    send(1'b0, 6'b111110, 6'd0,  1'b0, "R3", 1'b1);
    send(1'b0, 6'b111101, 6'd1,  1'b1, "R4", 1'b1);
    send(1'b0, 6'b111101, 6'd1,  1'b0, "R4", 1'b1);
    send(1'b1, 6'b111111, 6'd5,  1'b1, "R4", 1'b1);
    send(1'b1, 6'b111111, 6'd5,  1'b0, "R6", 1'b1);
    send(1'b0, 6'b000111, 6'd3,  1'b1, "R5", 1'b1);
    send(1'b0, 6'b100010, 6'd30, 1'b1, "R6", 1'b1);

    repeat (3) @(negedge clk);
    check(out_valid == 0, "R2", "strobe drops when idle", 64'(out_valid), 64'd0);
    check(wmask == last.w && tmask == last.t, "R2", "outputs hold", wmask, last.w);

    for (int lg = 0; lg < 2; lg++)
      for (int n = 0; n < 2; n++)
        for (int s = 0; s < 64; s++)
          for (int r = 0; r < 64; r++)
            send(n[0], 6'(s), 6'(r), lg[0], (n == 1) ? "R7" : "R3", 1'b0);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2", "results outstanding", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule